// File: doc/BRIEF.md
# Synchronous SRAM with Selectable Output Pipeline

This block is a single-port synchronous SRAM with a common data path and a choice of read latency. Address, write data, the three chip enables and the write controls are captured on the rising clock edge. A static mode input selects one of two read paths. In flow-through mode the array output goes straight to the data outputs. In pipelined mode the data passes through one more rising-edge register first. The read-valid flag passes through the same stages as the data. A deselect therefore stops output drive exactly one stage later in pipelined mode than in flow-through mode.

Writes are late writes. The command is registered on one edge and the array is updated on the next edge. A read issued in the cycle after a write therefore returns the new data. A global write stores every byte. Otherwise only bytes whose strobe is set are written, and only while the byte-write enable is high. The output enable and the sleep input act on the outputs combinationally. Sleep also blocks new commands from being captured and leaves the stored data unchanged. The shared data bus is modelled as a data output plus a drive flag: when the flag is low the bus is released and the data output reads zero.

Top module: `pipe_select_sram`

## Requirements
- R1: With `pipe_mode` low, a read captured on edge k drives `dq_o` with the word at that address and raises `dq_drive` after edge k.
- R2: With `pipe_mode` high, a read captured on edge k drives `dq_o` with the word at that address and raises `dq_drive` only after edge k+1.
- R3: A cycle captured without a read command (deselect, write or idle) removes drive after the same number of edges as a read takes to appear. In pipelined mode the last read stays on the bus through the cycle after the deselect edge and is released after the following edge.
- R4: When `gwr` is low, byte b (bits 8b+7..8b) is written only if `bwe` and `bstrb[b]` are both high. With `bwe` high and no strobe set, or with `bwe` low, no byte is written and the command is a read.
- R5: When `gwr` is high, all bytes at the address take `dq_i`, whatever `bwe` and `bstrb` are.
- R6: The device is selected only when `ce_a`=1, `ce_b`=1 and `ce_c_n`=0. Any other combination writes nothing and reads nothing.
- R7: `oe` low releases the bus within the same cycle, without waiting for a clock edge. Raising it again restores the pending read data.
- R8: While `sleep` is high the bus is released at once, commands captured on those edges are ignored, and the array contents are kept.
- R9: Whenever `dq_drive` is low, `dq_o` is all zeros.
- R10: After synchronous reset `rst`, the bus is not driven until a new read is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| pipe_mode | input | 1 | 1 = pipelined read path, 0 = flow-through |
| sleep | input | 1 | Asynchronous low-power request, active high |
| oe | input | 1 | Asynchronous output enable, active high |
| ce_a | input | 1 | Chip enable, active high |
| ce_b | input | 1 | Chip enable, active high |
| ce_c_n | input | 1 | Chip enable, active low |
| addr | input | ADDR_W (8) | Word address |
| gwr | input | 1 | Global write, all bytes |
| bwe | input | 1 | Byte-write enable |
| bstrb | input | NUM_BYTES (4) | Per-byte write strobes |
| dq_i | input | DATA_W (32) | Write data |
| dq_o | output | DATA_W (32) | Read data, zero when not driven |
| dq_drive | output | 1 | High when the block drives the data bus |

## Verification
The bound checker tests on every clock the timing relation between a read or non-read command at the ports and the later state of `dq_drive` in each mode. It also checks on every clock that output enable and sleep release the bus and that `dq_o` is zero whenever the bus is released. Data correctness needs a memory model, so only the bench can show it. The bench covers stored words after global writes and after every byte-strobe pattern, all chip-enable combinations, late-write read-after-write, retention through sleep, and the release of the bus in the middle of a cycle.

// File: rtl/sram_pkg.sv
package sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } sram_op_e;
endpackage

// File: rtl/sram_cmd_reg.sv
module sram_cmd_reg
   import sram_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8,
   localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 sleep,
   input  logic                 sel,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 gwr,
   input  logic                 bwe,
   input  logic [NUM_BYTES-1:0] bstrb,
   input  logic [DATA_W-1:0]    wdata,
   output sram_op_e             op_q,
   output logic [ADDR_W-1:0]    addr_q,
   output logic [NUM_BYTES-1:0] mask_q,
   output logic [DATA_W-1:0]    wdata_q
);
   logic [NUM_BYTES-1:0] lane_we;
   sram_op_e             op_d;

   // per-lane write decode: global write overrides the gated byte strobes
   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane_dec
      assign lane_we[b] = gwr | (bwe & bstrb[b]);
   end

   always_comb begin
      if (!sel || sleep)   op_d = OP_IDLE;
      else if (|lane_we)   op_d = OP_WRITE;
      else                 op_d = OP_READ;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q   <= OP_IDLE;
         mask_q <= '0;
      end else begin
         op_q   <= op_d;
         mask_q <= (op_d == OP_WRITE) ? lane_we : '0;
      end
      addr_q  <= addr;
      wdata_q <= wdata;
   end
endmodule

// File: rtl/sram_array.sv
module sram_array #(
   parameter int DEPTH     = 256,
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8,
   localparam int ADDR_W   = $clog2(DEPTH),
   localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic [NUM_BYTES-1:0] wmask,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata
);
   for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] store [DEPTH];

      always_ff @(posedge clk) begin
         if (wmask[b]) store[addr] <= wdata[b*BYTE_W +: BYTE_W];
      end

      assign rdata[b*BYTE_W +: BYTE_W] = store[addr];
   end
endmodule

// File: rtl/sram_read_path.sv
module sram_read_path #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pipe_mode,
   input  logic              rd_now,
   input  logic [DATA_W-1:0] arr_data,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   logic              rd_late;
   logic [DATA_W-1:0] data_late;

   // the valid flag follows the data stage so deselects age like reads
   always_ff @(posedge clk) begin
      if (rst) rd_late <= 1'b0;
      else     rd_late <= rd_now;
      if (rd_now) data_late <= arr_data;
   end

   assign rd_valid = pipe_mode ? rd_late   : rd_now;
   assign rd_data  = pipe_mode ? data_late : arr_data;
endmodule

// File: rtl/pipe_select_sram.sv
module pipe_select_sram
   import sram_pkg::*;
#(
   parameter int DEPTH     = 256,
   parameter int NUM_BYTES = 4,
   parameter int BYTE_W    = 8,
   localparam int ADDR_W   = $clog2(DEPTH),
   localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 pipe_mode,
   input  logic                 sleep,
   input  logic                 oe,
   input  logic                 ce_a,
   input  logic                 ce_b,
   input  logic                 ce_c_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 gwr,
   input  logic                 bwe,
   input  logic [NUM_BYTES-1:0] bstrb,
   input  logic [DATA_W-1:0]    dq_i,
   output logic [DATA_W-1:0]    dq_o,
   output logic                 dq_drive
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("pipe_select_sram: DEPTH must be at least 2");
   end
   if (NUM_BYTES < 1 || BYTE_W < 1) begin : g_bad_width
      $error("pipe_select_sram: byte count and byte width must be positive");
   end

   sram_op_e             op_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [NUM_BYTES-1:0] mask_q;
   logic [DATA_W-1:0]    wdata_q;
   logic [DATA_W-1:0]    arr_data;
   logic                 rd_valid;
   logic [DATA_W-1:0]    rd_data;
   logic                 selected;

   assign selected = ce_a & ce_b & ~ce_c_n;

   sram_cmd_reg #(
      .ADDR_W   (ADDR_W),
      .NUM_BYTES(NUM_BYTES),
      .BYTE_W   (BYTE_W)
   ) u_cmd (
      .clk    (clk),
      .rst    (rst),
      .sleep  (sleep),
      .sel    (selected),
      .addr   (addr),
      .gwr    (gwr),
      .bwe    (bwe),
      .bstrb  (bstrb),
      .wdata  (dq_i),
      .op_q   (op_q),
      .addr_q (addr_q),
      .mask_q (mask_q),
      .wdata_q(wdata_q)
   );

   sram_array #(
      .DEPTH    (DEPTH),
      .NUM_BYTES(NUM_BYTES),
      .BYTE_W   (BYTE_W)
   ) u_array (
      .clk  (clk),
      .wmask(mask_q),
      .addr (addr_q),
      .wdata(wdata_q),
      .rdata(arr_data)
   );

   sram_read_path #(
      .DATA_W(DATA_W)
   ) u_rd (
      .clk      (clk),
      .rst      (rst),
      .pipe_mode(pipe_mode),
      .rd_now   (op_q == OP_READ),
      .arr_data (arr_data),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assign dq_drive = rd_valid & oe & ~sleep;
   assign dq_o     = dq_drive ? rd_data : '0;
endmodule

// File: rtl/pipe_select_sram_chk.sv
module pipe_select_sram_chk #(
   parameter int ADDR_W    = 8,
   parameter int NUM_BYTES = 4,
   parameter int DATA_W    = 32
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 pipe_mode,
   input logic                 sleep,
   input logic                 oe,
   input logic                 ce_a,
   input logic                 ce_b,
   input logic                 ce_c_n,
   input logic                 gwr,
   input logic                 bwe,
   input logic [NUM_BYTES-1:0] bstrb,
   input logic [DATA_W-1:0]    dq_o,
   input logic                 dq_drive
);
   logic port_read;
   assign port_read = ce_a && ce_b && !ce_c_n && !sleep && !gwr && !(bwe && (|bstrb));

   // R1
   flow_read_drives_chk: assert property (@(posedge clk) disable iff (rst)
      (!pipe_mode && $past(port_read) && !$past(rst) && oe && !sleep) |-> dq_drive);

   // R2
   pipe_read_drives_chk: assert property (@(posedge clk) disable iff (rst)
      (pipe_mode && $past(port_read, 2) && !$past(rst) && !$past(rst, 2) && oe && !sleep) |-> dq_drive);

   // R3
   pipe_deselect_release_chk: assert property (@(posedge clk) disable iff (rst)
      (pipe_mode && !$past(port_read, 2)) |-> !dq_drive);

   // R3
   flow_deselect_release_chk: assert property (@(posedge clk) disable iff (rst)
      (!pipe_mode && !$past(port_read)) |-> !dq_drive);

   // R7
   oe_release_chk: assert property (@(posedge clk) disable iff (rst)
      !oe |-> !dq_drive);

   // R8
   sleep_release_chk: assert property (@(posedge clk) disable iff (rst)
      sleep |-> !dq_drive);

   // R9
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !dq_drive |-> (dq_o == '0));

   // R10
   reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !dq_drive);
endmodule

bind pipe_select_sram pipe_select_sram_chk #(
   .ADDR_W   (ADDR_W),
   .NUM_BYTES(NUM_BYTES),
   .DATA_W   (DATA_W)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pipe_mode(pipe_mode),
   .sleep    (sleep),
   .oe       (oe),
   .ce_a     (ce_a),
   .ce_b     (ce_b),
   .ce_c_n   (ce_c_n),
   .gwr      (gwr),
   .bwe      (bwe),
   .bstrb    (bstrb),
   .dq_o     (dq_o),
   .dq_drive (dq_drive)
);

// File: tb/pipe_select_sram_test.sv
module pipe_select_sram_test;
   localparam int DEPTH = 256;
   localparam int NB    = 4;
   localparam int BW    = 8;
   localparam int AW    = $clog2(DEPTH);
   localparam int DW    = NB * BW;

   logic          clk = 1'b0;
   logic          rst, pipe_mode, sleep, oe, ce_a, ce_b, ce_c_n, gwr, bwe;
   logic [AW-1:0] addr;
   logic [NB-1:0] bstrb;
   logic [DW-1:0] dq_i, dq_o;
   logic          dq_drive;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] model [DEPTH];
   logic          hist_rd [2];
   logic [DW-1:0] hist_d  [2];

   always #5 clk = ~clk;

   pipe_select_sram #(.DEPTH(DEPTH), .NUM_BYTES(NB), .BYTE_W(BW)) uut (
      .clk(clk), .rst(rst), .pipe_mode(pipe_mode), .sleep(sleep), .oe(oe),
      .ce_a(ce_a), .ce_b(ce_b), .ce_c_n(ce_c_n), .addr(addr), .gwr(gwr),
      .bwe(bwe), .bstrb(bstrb), .dq_i(dq_i), .dq_o(dq_o), .dq_drive(dq_drive)
   );

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      return (32'h9E37_79B9 * (a + 1)) ^ (32'h0101_0101 * salt) ^ {a[7:0], 24'h5A3C00};
   endfunction

   task automatic compare(input string tag, input logic exp_drv, input logic [DW-1:0] exp_d);
      checks++;
      if (dq_drive !== exp_drv || dq_o !== exp_d) begin
         errors++;
         $display("FAIL %s: drive=%0b data=%h, expected drive=%0b data=%h",
                  tag, dq_drive, dq_o, exp_drv, exp_d);
      end
   endtask

   task automatic check_now(input string tag);
      int lat = pipe_mode ? 2 : 1;
      logic ed = hist_rd[lat-1] && oe && !sleep;
      compare(tag, ed, ed ? hist_d[lat-1] : '0);
   endtask

   // issue the command on the current inputs, pass one edge, then check
   task automatic issue(input string tag);
      logic sel = ce_a && ce_b && !ce_c_n && !sleep;
      logic [NB-1:0] m;
      logic rd;
      for (int b = 0; b < NB; b++) m[b] = gwr || (bwe && bstrb[b]);
      rd = sel && (m == '0);
      hist_rd[1] = hist_rd[0];
      hist_d[1]  = hist_d[0];
      hist_rd[0] = rd;
      hist_d[0]  = model[addr];
      if (sel && m != '0)
         for (int b = 0; b < NB; b++)
            if (m[b]) model[addr][b*BW +: BW] = dq_i[b*BW +: BW];
      @(negedge clk);
      check_now(tag);
   endtask

   task automatic set_cmd(input logic [AW-1:0] a, input logic g, input logic be,
                          input logic [NB-1:0] s, input logic [DW-1:0] d);
      addr = a; gwr = g; bwe = be; bstrb = s; dq_i = d;
      ce_a = 1'b1; ce_b = 1'b1; ce_c_n = 1'b0;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         ce_a = 1'b0; gwr = 1'b0; bwe = 1'b0; bstrb = '0;
         issue(tag);
      end
   endtask

   task automatic read_all(input string tag);
      for (int a = 0; a < DEPTH; a++) begin
         set_cmd(a[AW-1:0], 1'b0, 1'b0, '0, '0);
         issue(tag);
      end
      idle(2, tag);
   endtask

   initial begin
      for (int i = 0; i < 2; i++) begin hist_rd[i] = 1'b0; hist_d[i] = '0; end
      for (int a = 0; a < DEPTH; a++) model[a] = '0;
      rst = 1'b1; pipe_mode = 1'b1; sleep = 1'b0; oe = 1'b1;
      ce_a = 1'b0; ce_b = 1'b0; ce_c_n = 1'b1; addr = '0;
      gwr = 1'b0; bwe = 1'b0; bstrb = '0; dq_i = '0;
      repeat (3) @(negedge clk);
      // R10: quiet bus in and right after reset
      compare("R10 in reset", 1'b0, '0);
      rst = 1'b0;
      idle(2, "R10 after reset");

      // R5: global write fills every word, byte controls random
      for (int a = 0; a < DEPTH; a++) begin
         set_cmd(a[AW-1:0], 1'b1, a[0], a[4:1], pat(a, 1));
         issue("R5 fill");
      end
      idle(2, "R5");
      read_all("R2 pipelined read");
      pipe_mode = 1'b0;
      idle(3, "R1");
      read_all("R1 flow read");

      // R4: every strobe pattern with byte-write enable on and off
      for (int m = 0; m < 2 * (1 << NB); m++) begin
         for (int p = 0; p < 2; p++) begin
            pipe_mode = p[0];
            idle(3, "R4");
            set_cmd(m[AW-1:0] + 8'(p * 64), 1'b0, m[NB], m[NB-1:0], pat(m, 7 + p));
            issue("R4 byte write");
            set_cmd(m[AW-1:0] + 8'(p * 64), 1'b0, 1'b0, '0, '0);
            issue("R4 read after write");
            idle(2, "R4 readback");
         end
      end

      // R6: every chip-enable combination, write then read
      for (int c = 0; c < 8; c++) begin
         pipe_mode = c[0];
         idle(3, "R6");
         set_cmd(8'(100 + c), 1'b1, 1'b0, '0, pat(c, 11));
         {ce_a, ce_b, ce_c_n} = c[2:0];
         issue("R6 write");
         set_cmd(8'(100 + c), 1'b0, 1'b0, '0, '0);
         {ce_a, ce_b, ce_c_n} = c[2:0];
         issue("R6 read");
         set_cmd(8'(100 + c), 1'b0, 1'b0, '0, '0);
         issue("R6 selected read");
         idle(2, "R6 readback");
      end

      // R3: read bursts cut by a deselect, both modes
      for (int p = 0; p < 2; p++) begin
         pipe_mode = p[0];
         idle(3, "R3");
         for (int k = 0; k < 3; k++) begin
            set_cmd(8'(20 + k), 1'b0, 1'b0, '0, '0);
            issue("R3 read before deselect");
         end
         ce_b = 1'b0;
         issue("R3 deselect edge");
         issue("R3 after deselect");
         issue("R3 second edge after deselect");
      end

      // R7: output enable drops and returns between edges
      pipe_mode = 1'b1;
      idle(3, "R7");
      for (int k = 0; k < 8; k++) begin
         set_cmd(8'(40 + k), 1'b0, 1'b0, '0, '0);
         oe = k[0];
         issue("R7 oe per cycle");
      end
      oe = 1'b1;
      set_cmd(8'd50, 1'b0, 1'b0, '0, '0);
      issue("R7");
      issue("R7 pipelined data");
      oe = 1'b0; #1; compare("R7 async release", 1'b0, '0);
      oe = 1'b1; #1; compare("R7 async restore", 1'b1, model[50]);

      // R8: sleep mid-read releases at once; writes in sleep are dropped
      sleep = 1'b1; #1; compare("R8 async sleep", 1'b0, '0);
      for (int k = 0; k < 16; k++) begin
         set_cmd(8'(k * 16), 1'b1, 1'b1, 4'hF, ~pat(k, 3));
         issue("R8 write in sleep");
      end
      sleep = 1'b0;
      idle(3, "R8");
      read_all("R8 retention");

      // R9: random mixed traffic, zero bus whenever released
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r = $urandom;
         if (i % 500 == 0) begin
            idle(2, "R9");
            pipe_mode = r[20];
         end
         set_cmd(r[7:0], r[8] & r[9], r[10], r[14:11], pat(i, 5));
         ce_a = r[15] | r[16];
         oe = r[17] | r[18];
         sleep = r[19] & r[21] & r[22];
         issue("R9 mixed traffic");
      end
      sleep = 1'b0; oe = 1'b1;
      idle(3, "R9");
      read_all("R9 final contents");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule